// File: doc/BRIEF.md
# Transfer Descriptor Checksum Unit

This block produces and verifies the one-byte integrity code that protects a 16-byte transfer descriptor. The code is the 8-bit sum of the descriptor bytes, taken with the code byte itself counted as zero. The sum is then raised by one, as if the hardware-ownership flag were set, and the result is subtracted from 0xFF. The unit compares the code it computes with the code byte the descriptor already carries and reports whether the two agree.

A descriptor reaches the block in one of two ways. It can arrive as one 128-bit word, which is checked in a single cycle. It can also be streamed one byte per cycle through a valid/ready handshake. A start pulse opens each computation and selects the path. A one-cycle done strobe marks the moment when the computed code and the match flag become valid. The match flag then holds its value until the next start pulse.

Top module: `desc_csum_unit`

## Requirements
- R1: The computed code equals 0xFF minus ((sum of the 16 descriptor bytes modulo 256) + 1). Byte index 1 is counted as zero, and bit 0 of byte index 0 is counted as zero.
- R2: In word mode, a start pulse with `word_mode` high checks `desc_word`, where byte index i is `desc_word[8*i+7:8*i]`. `done` is high in the cycle after that start.
- R3: In stream mode, `s_ready` rises in the cycle after a start with `word_mode` low. It stays high until the 16th byte is accepted and is low in the cycle after that. Bytes are accepted in index order, starting at byte 0.
- R4: `done` pulses for exactly one cycle, two cycles after the clock edge that accepts the 16th streamed byte.
- R5: `match` is high only when the computed code equals the stored byte at index 1. It keeps its value until the next start pulse.
- R6: Every start pulse discards any partial stream sum. A start with `word_mode` low also clears `csum`, `match` and `done` in the following cycle.
- R7: A synchronous active-high reset drives `csum` to 0 and `match`, `done` and `s_ready` low.
- R8: A streamed byte counts only on a cycle where `s_valid` and `s_ready` are both high. Data on other cycles, including cycles after the 16th byte, changes neither `csum` nor `done`.
- R9: The value of bit 0 of byte index 0 (the ownership flag) has no effect on `csum` or `match`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a computation |
| word_mode | input | 1 | Selects the path at start: 1 = whole word, 0 = byte stream |
| desc_word | input | 128 | Descriptor for word mode, with byte i at bits 8i+7:8i |
| s_valid | input | 1 | A streamed byte is present |
| s_data | input | 8 | Streamed descriptor byte |
| s_ready | output | 1 | The unit accepts streamed bytes |
| csum | output | 8 | Computed checksum |
| match | output | 1 | The computed code equals stored byte 1 |
| done | output | 1 | One-cycle strobe: result valid |

## Verification
The hardest cases to reach are a restart arriving in the middle of a stream and data arriving on a cycle the unit ignores. The bench starts a stream, feeds five bytes, then pulses start again and feeds a different descriptor. The result it checks matches only the second descriptor. To cover ignored data, the bench inserts idle cycles that carry junk data between streamed bytes. It also keeps pushing valid bytes after the 16th byte has been accepted, and then confirms at the ports that `csum` and `done` did not move.

// File: rtl/desc_csum_pkg.sv
package desc_csum_pkg;
    parameter int DESC_BYTES = 16;
    parameter int BYTE_W     = 8;
    parameter int CODE_POS   = 1;
    parameter int FLAG_POS   = 0;
    parameter int OWN_BIT    = 0;

    localparam int DESC_W = DESC_BYTES * BYTE_W;
    localparam int CNT_W  = $clog2(DESC_BYTES);

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        byte_t code;
        logic  hit;
    } verdict_t;

    // The contribution of one descriptor byte to the running sum
    function automatic byte_t byte_term(int unsigned idx, byte_t b);
        byte_t v;
        v = b;
        if (idx == CODE_POS) begin
            v = '0;
        end else if (idx == FLAG_POS) begin
            v[OWN_BIT] = 1'b0;
        end
        return v;
    endfunction

    // Add the ownership bias, complement from all-ones, compare with the stored code
    function automatic verdict_t judge(byte_t sum, byte_t stored);
        verdict_t r;
        r.code = byte_t'('1) - byte_t'(sum + byte_t'(1));
        r.hit  = (r.code == stored);
        return r;
    endfunction
endpackage

// File: rtl/csum_word_adder.sv
module csum_word_adder
    import desc_csum_pkg::*;
(
    input  logic [DESC_W-1:0] desc,
    output byte_t             sum,
    output byte_t             stored
);
    byte_t terms [DESC_BYTES];

    for (genvar i = 0; i < DESC_BYTES; i++) begin : g_term
        assign terms[i] = byte_term(i, desc[i*BYTE_W +: BYTE_W]);
    end

    always_comb begin
        sum = '0;
        for (int i = 0; i < DESC_BYTES; i++) begin
            sum = sum + terms[i];
        end
    end

    assign stored = desc[CODE_POS*BYTE_W +: BYTE_W];
endmodule

// File: rtl/csum_stream_acc.sv
module csum_stream_acc
    import desc_csum_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clear,
    input  logic  arm,
    input  logic  in_valid,
    input  byte_t in_data,
    output logic  in_ready,
    output logic  fin,
    output byte_t sum,
    output byte_t stored
);
    logic             busy;
    logic [CNT_W-1:0] idx;
    logic             take;

    assign in_ready = busy;
    assign take     = in_valid && busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            idx    <= '0;
            sum    <= '0;
            stored <= '0;
            fin    <= 1'b0;
        end else if (clear) begin
            busy   <= arm;
            idx    <= '0;
            sum    <= '0;
            stored <= '0;
            fin    <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (take) begin
                sum <= sum + byte_term(int'(idx), in_data);
                if (int'(idx) == CODE_POS) begin
                    stored <= in_data;
                end
                if (idx == CNT_W'(DESC_BYTES - 1)) begin
                    busy <= 1'b0;
                    fin  <= 1'b1;
                    idx  <= '0;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/csum_result_reg.sv
module csum_result_reg
    import desc_csum_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  logic  word_mode,
    input  byte_t w_sum,
    input  byte_t w_stored,
    input  logic  s_fin,
    input  byte_t s_sum,
    input  byte_t s_stored,
    output byte_t csum,
    output logic  match,
    output logic  done
);
    verdict_t w_res, s_res;

    assign w_res = judge(w_sum, w_stored);
    assign s_res = judge(s_sum, s_stored);

    always_ff @(posedge clk) begin
        if (rst) begin
            csum  <= '0;
            match <= 1'b0;
            done  <= 1'b0;
        end else if (start && word_mode) begin
            csum  <= w_res.code;
            match <= w_res.hit;
            done  <= 1'b1;
        end else if (start) begin
            csum  <= '0;
            match <= 1'b0;
            done  <= 1'b0;
        end else if (s_fin) begin
            csum  <= s_res.code;
            match <= s_res.hit;
            done  <= 1'b1;
        end else begin
            done  <= 1'b0;
        end
    end
endmodule

// File: rtl/desc_csum_unit.sv
module desc_csum_unit
    import desc_csum_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              word_mode,
    input  logic [DESC_W-1:0] desc_word,
    input  logic              s_valid,
    input  logic [BYTE_W-1:0] s_data,
    output logic              s_ready,
    output logic [BYTE_W-1:0] csum,
    output logic              match,
    output logic              done
);
    byte_t w_sum, w_stored, s_sum, s_stored;
    logic  s_fin;

    csum_word_adder u_word (
        .desc   (desc_word),
        .sum    (w_sum),
        .stored (w_stored)
    );

    csum_stream_acc u_stream (
        .clk      (clk),
        .rst      (rst),
        .clear    (start),
        .arm      (!word_mode),
        .in_valid (s_valid),
        .in_data  (s_data),
        .in_ready (s_ready),
        .fin      (s_fin),
        .sum      (s_sum),
        .stored   (s_stored)
    );

    csum_result_reg u_result (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .word_mode (word_mode),
        .w_sum     (w_sum),
        .w_stored  (w_stored),
        .s_fin     (s_fin),
        .s_sum     (s_sum),
        .s_stored  (s_stored),
        .csum      (csum),
        .match     (match),
        .done      (done)
    );
endmodule

// File: rtl/desc_csum_unit_chk.sv
module desc_csum_unit_chk
    import desc_csum_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              word_mode,
    input logic              s_valid,
    input logic              s_ready,
    input logic [BYTE_W-1:0] csum,
    input logic              match,
    input logic              done
);
    logic [CNT_W:0] seen;
    logic           rst_q = 1'b0;
    logic           accept;

    assign accept = s_valid && s_ready;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst || start) begin
            seen <= '0;
        end else if (accept) begin
            seen <= seen + 1'b1;
        end
    end

    // R7: every output is quiet in the cycle after reset
    always @(posedge clk) begin
        if (rst_q) begin
            assert_reset_state_R7: assert (!done && !s_ready && !match && csum == '0);
        end
    end

    assert_word_done_R2: assert property (@(posedge clk) disable iff (rst)
        (start && word_mode) |=> done);

    assert_ready_drop_R3: assert property (@(posedge clk) disable iff (rst)
        (accept && !start && seen == (CNT_W+1)'(DESC_BYTES - 1)) |=> !s_ready);

    assert_done_after_last_R4: assert property (@(posedge clk) disable iff (rst)
        (accept && !start && seen == (CNT_W+1)'(DESC_BYTES - 1)) |=> ##1 (done || $past(start)));

    assert_match_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !start |=> ($stable(match) || done));

    assert_start_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (start && !word_mode) |=> (!match && csum == '0 && !done));
endmodule

bind desc_csum_unit desc_csum_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .word_mode (word_mode),
    .s_valid   (s_valid),
    .s_ready   (s_ready),
    .csum      (csum),
    .match     (match),
    .done      (done)
);

// File: tb/desc_csum_unit_bench.sv
module desc_csum_unit_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         word_mode = 1'b0;
    logic [127:0] desc_word = '0;
    logic         s_valid = 1'b0;
    logic [7:0]   s_data = '0;
    logic         s_ready;
    logic [7:0]   csum;
    logic         match;
    logic         done;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    desc_csum_unit u_desc_csum_unit (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .word_mode (word_mode),
        .desc_word (desc_word),
        .s_valid   (s_valid),
        .s_data    (s_data),
        .s_ready   (s_ready),
        .csum      (csum),
        .match     (match),
        .done      (done)
    );

    function automatic logic [7:0] ref_code(logic [127:0] d);
        logic [7:0] s;
        logic [7:0] b;
        s = 8'd1;
        for (int i = 0; i < 16; i++) begin
            b = d[i*8 +: 8];
            if (i == 1) b = 8'h00;
            if (i == 0) b[0] = 1'b0;
            s = s + b;
        end
        return 8'hFF - s;
    endfunction

    function automatic logic [127:0] with_code(logic [127:0] d);
        logic [127:0] r;
        r = d;
        r[15:8] = ref_code(d);
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse_start(input logic wm, input logic [127:0] d);
        @(negedge clk);
        start = 1'b1;
        word_mode = wm;
        desc_word = d;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_word(input logic [127:0] d, input string req);
        pulse_start(1'b1, d);
        check(done == 1'b1, req, done, 1);
        check(csum == ref_code(d), req, csum, ref_code(d));
        check(match == (d[15:8] == ref_code(d)), req, match, d[15:8] == ref_code(d));
    endtask

    task automatic feed_bytes(input logic [127:0] d, input int from, input int upto, input bit gaps);
        for (int i = from; i < upto; i++) begin
            if (gaps && (i % 3 == 1)) begin
                s_valid = 1'b0;
                s_data = 8'hA5 ^ 8'(i);
                @(negedge clk);
            end
            s_valid = 1'b1;
            s_data = d[i*8 +: 8];
            @(negedge clk);
        end
        s_valid = 1'b0;
        s_data = 8'h3C;
    endtask

    task automatic run_stream(input logic [127:0] d, input bit gaps, input string req);
        logic [7:0] exp_code;
        exp_code = ref_code(d);
        pulse_start(1'b0, '0);
        check(s_ready == 1'b1, "R3", s_ready, 1);
        feed_bytes(d, 0, 16, gaps);
        check(s_ready == 1'b0, "R3", s_ready, 0);
        check(done == 1'b0, "R4", done, 0);
        @(negedge clk);
        check(done == 1'b1, "R4", done, 1);
        check(csum == exp_code, req, csum, exp_code);
        check(match == (d[15:8] == exp_code), "R5", match, d[15:8] == exp_code);
        @(negedge clk);
        check(done == 1'b0, "R4", done, 0);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(csum == 8'h00 && !match && !done && !s_ready, "R7", {csum, match, done, s_ready}, 0);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_word;
        run_word('0, "R1");
        check(csum == 8'hFE, "R1", csum, 8'hFE);
        run_word({128{1'b1}}, "R1");
        check(csum == 8'h0E, "R1", csum, 8'h0E);
        run_word(128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0, "R2");
        run_word(with_code(128'h00112233_44556677_8899AABB_CCDDEE00), "R2");
        check(match == 1'b1, "R5", match, 1);
    endtask

    task automatic t_owned;
        logic [127:0] a, b;
        a = with_code(128'h13579BDF_2468ACE0_FEDCBA98_76543200);
        b = a;
        b[0] = 1'b1;
        run_word(b, "R9");
        check(match == 1'b1, "R9", match, 1);
        check(csum == ref_code(a), "R9", csum, ref_code(a));
    endtask

    task automatic t_stream;
        logic [127:0] d;
        d = with_code(128'hDEADBEEF_CAFEF00D_01020304_05060781);
        run_stream(d, 1'b0, "R1");
        run_stream(128'h11111111_22222222_33333333_44444444, 1'b1, "R8");
        // match hold: idle cycles then junk pushes while not ready
        repeat (3) @(negedge clk);
        s_valid = 1'b1;
        s_data = 8'h77;
        repeat (4) @(negedge clk);
        s_valid = 1'b0;
        check(done == 1'b0, "R8", done, 0);
        check(csum == ref_code(128'h11111111_22222222_33333333_44444444), "R8", csum,
              ref_code(128'h11111111_22222222_33333333_44444444));
        check(match == 1'b0, "R5", match, 0);
    endtask

    task automatic t_restart;
        logic [127:0] d;
        d = with_code(128'h0A0B0C0D_0E0F1011_12131415_16171819);
        run_word(d, "R6");
        pulse_start(1'b0, '0);
        feed_bytes(128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF, 0, 5, 1'b0);
        pulse_start(1'b0, '0);
        check(csum == 8'h00 && !match && !done, "R6", {csum, match, done}, 0);
        feed_bytes(d, 0, 16, 1'b1);
        @(negedge clk);
        check(done == 1'b1, "R6", done, 1);
        check(csum == ref_code(d) && match, "R6", csum, ref_code(d));
    endtask

    task automatic t_reset_mid;
        pulse_start(1'b0, '0);
        feed_bytes(128'h55, 0, 7, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(!s_ready && !done && csum == 8'h00 && !match, "R7", {s_ready, done, csum, match}, 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_word();
        t_owned();
        t_stream();
        t_restart();
        t_reset_mid();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule